// File: doc/BRIEF.md
# Flash erase command sequencer

This block is the command front end of a NOR-style flash device. It watches the bus write cycles, which carry an address and a data byte, and recognises the multi-cycle command strings that start a whole-device erase or a single-sector erase. It also recognises the short commands that pause and continue a sector erase, and the identification-mode entry. Each accepted erase runs on an internal down-counter that stands in for the embedded erase. That erase also covers the internal pre-programming to zero, so the host issues no preparatory writes. The block records which sectors are being erased and accepts only the commands that the current state allows.

The read path asks the block about the sector of each read. A high `rd_status` means the read must return status instead of array contents. Status reporting is reduced to a busy flag and a suspended flag. A separate program engine raises `prog_active` while it owns the device. During that time this sequencer treats every write as absent.

All addresses are word addresses. The unlock checks compare only the low 11 address bits. The sector number is the top `$clog2(NUM_SECT)` bits of the address.

Top module: `fes_seq`

## Requirements
- R1: The write string 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA, 0x10@0x555 starts a whole-device erase. From the cycle after the sixth write, `busy` is high for exactly CHIP_CYC cycles and `sect_sel` is all ones.
- R2: The same first five writes, followed by 0x30 at any address, start a sector erase of the sector given by the top address bits of that sixth write. That sector's bit alone is set in `sect_sel`, and `busy` lasts SECT_CYC cycles of active erasing.
- R3: A write whose address or data does not match the expected step of the string returns the sequencer to read mode. The steps already matched are lost.
- R4: During a whole-device erase, every write is ignored, including 0xB0.
- R5: During an active sector erase, only 0xB0 (at any address) has an effect. All other writes are ignored.
- R6: After an accepted 0xB0, `busy` stays high for SUSP_LAT cycles and then `suspended` rises. SUSP_LAT is bounded at elaboration to 20 us of clock cycles. `busy` and `suspended` are never high together.
- R7: While an erase is active or suspended, `rd_status` is high exactly when `rd_sector` names a selected sector. Reads of other sectors return array data.
- R8: While suspended, 0x30 at any address resumes the erase. The erase timer holds during the pause and continues from the remaining count.
- R9: While suspended, every write other than 0x30 is ignored, and the identification string (0xAA, 0x55, 0x90) does not raise `id_mode`.
- R10: When the erase timer expires, the sequencer returns to read mode: `busy` drops, `sect_sel` clears and `rd_status` goes low.
- R11: While `prog_active` is high, writes have no effect in any state, 0xB0 included.
- R12: In read mode, 0xAA@0x555, 0x55@0x2AA, 0x90@0x555 raises `id_mode`. While `id_mode` is high, only 0xF0 clears it.
- R13: An 0xB0 written in the final cycle of a sector erase is ignored. The erase completes and no pause follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One bus write cycle is present |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | 8 | Command byte of the write |
| prog_active | input | 1 | Program engine owns the device; writes are ignored |
| rd_sector | input | $clog2(NUM_SECT) | Sector number of the current read |
| busy | output | 1 | Erase running or suspend pending |
| suspended | output | 1 | Sector erase paused |
| id_mode | output | 1 | Identification mode active |
| sect_sel | output | NUM_SECT | Sectors selected for erase |
| rd_status | output | 1 | Current read must return status |

## Verification
The bench drives complete erase strings into different sectors, and strings that break off at the address step and at the data step. It also sends identification strings into read mode and into the suspended state, to show that the same bytes act differently depending on the state. Stray commands are written during whole-device and sector erases, and a suspend is tried while `prog_active` is high, so that ignored writes can be told apart from accepted ones. The pause-and-continue path is timed end to end, to show that the erase time excludes the suspended interval, and a suspend placed in the last erase cycle shows that completion takes priority.

// File: rtl/fes_pkg.sv
package fes_pkg;

   typedef enum logic [3:0] {
      ST_READ, ST_UNL1, ST_UNL2, ST_SETUP, ST_UNL3, ST_UNL4,
      ST_CHIP, ST_SECT, ST_SWAIT, ST_SUSP, ST_IDENT
   } fes_state_e;

   localparam logic [7:0]  CMD_KEY_A  = 8'hAA;
   localparam logic [7:0]  CMD_KEY_B  = 8'h55;
   localparam logic [7:0]  CMD_SETUP  = 8'h80;
   localparam logic [7:0]  CMD_CHIP   = 8'h10;
   localparam logic [7:0]  CMD_SECT   = 8'h30;
   localparam logic [7:0]  CMD_SUSP   = 8'hB0;
   localparam logic [7:0]  CMD_RESUME = 8'h30;
   localparam logic [7:0]  CMD_IDENT  = 8'h90;
   localparam logic [7:0]  CMD_RESET  = 8'hF0;
   localparam logic [10:0] ADR_KEY_A  = 11'h555;
   localparam logic [10:0] ADR_KEY_B  = 11'h2AA;

   typedef struct packed {
      logic wr;
      logic key_a;
      logic key_b;
      logic setup;
      logic chip;
      logic sect;
      logic susp;
      logic resume;
      logic ident;
      logic reset;
   } fes_cmd_t;

endpackage

// File: rtl/fes_decode.sv
module fes_decode
   import fes_pkg::*;
(
   input  logic        wr_en,
   input  logic        prog_active,
   input  logic [10:0] key_addr,
   input  logic [7:0]  data,
   output fes_cmd_t    cmd
);
   logic wr, at_a, at_b;

   assign wr   = wr_en & ~prog_active;
   assign at_a = (key_addr == ADR_KEY_A);
   assign at_b = (key_addr == ADR_KEY_B);

   always_comb begin
      cmd        = '0;
      cmd.wr     = wr;
      cmd.key_a  = wr & at_a & (data == CMD_KEY_A);
      cmd.key_b  = wr & at_b & (data == CMD_KEY_B);
      cmd.setup  = wr & at_a & (data == CMD_SETUP);
      cmd.chip   = wr & at_a & (data == CMD_CHIP);
      cmd.sect   = wr & (data == CMD_SECT);
      cmd.susp   = wr & (data == CMD_SUSP);
      cmd.resume = wr & (data == CMD_RESUME);
      cmd.ident  = wr & at_a & (data == CMD_IDENT);
      cmd.reset  = wr & (data == CMD_RESET);
   end
endmodule

// File: rtl/fes_cnt.sv
module fes_cnt #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         dec,
   output logic [W-1:0] cnt,
   output logic         last
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (load)   cnt <= load_val;
      else if (dec)    cnt <= cnt - W'(1);
   end

   assign last = (cnt == W'(1));

   // R8: the remaining count is frozen whenever it is neither loaded nor stepped
   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !dec) |=> $stable(cnt));
   // R8: the count never steps below zero
   assert_no_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      dec |-> (cnt != '0));
endmodule

// File: rtl/fes_sect_map.sv
module fes_sect_map #(
   parameter int NUM_SECT = 8,
   localparam int SW = $clog2(NUM_SECT)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                set_one,
   input  logic                set_all,
   input  logic                clr,
   input  logic [SW-1:0]       wr_idx,
   input  logic [SW-1:0]       rd_idx,
   output logic [NUM_SECT-1:0] sel,
   output logic                rd_hit
);
   for (genvar g = 0; g < NUM_SECT; g++) begin : g_sect
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                              sel[g] <= 1'b0;
         else if (clr)                            sel[g] <= 1'b0;
         else if (set_all)                        sel[g] <= 1'b1;
         else if (set_one && wr_idx == SW'(g))    sel[g] <= 1'b1;
      end
   end

   assign rd_hit = sel[rd_idx];

   // R2: a single-sector selection marks exactly one sector
   assert_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (set_one && !clr) |=> $onehot(sel));
endmodule

// File: rtl/fes_seq.sv
module fes_seq
   import fes_pkg::*;
#(
   parameter int ADDR_W   = 12,
   parameter int NUM_SECT = 8,
   parameter int CHIP_CYC = 4096,
   parameter int SECT_CYC = 1024,
   parameter int SUSP_LAT = 8,
   parameter int CLK_MHZ  = 100,
   localparam int SECT_W  = $clog2(NUM_SECT),
   localparam int TMR_MAX = (CHIP_CYC > SECT_CYC) ? CHIP_CYC : SECT_CYC,
   localparam int TMR_W   = $clog2(TMR_MAX) + 1,
   localparam int LAT_W   = $clog2(SUSP_LAT) + 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   wr_addr,
   input  logic [7:0]          wr_data,
   input  logic                prog_active,
   input  logic [SECT_W-1:0]   rd_sector,
   output logic                busy,
   output logic                suspended,
   output logic                id_mode,
   output logic [NUM_SECT-1:0] sect_sel,
   output logic                rd_status
);
   if (ADDR_W < 11 || ADDR_W < SECT_W + 1) begin : g_bad_addr
      $error("fes_seq: ADDR_W too small for unlock addresses");
   end
   if (NUM_SECT < 2 || (1 << SECT_W) != NUM_SECT) begin : g_bad_sect
      $error("fes_seq: NUM_SECT must be a power of two, at least 2");
   end
   if (CHIP_CYC < 2 || SECT_CYC < 2 || SUSP_LAT < 1) begin : g_bad_time
      $error("fes_seq: erase and suspend times out of range");
   end
   if (SUSP_LAT > 20 * CLK_MHZ) begin : g_bad_lat
      $error("fes_seq: suspend latency exceeds 20 us");
   end

   localparam logic [TMR_W-1:0] CHIP_LD = TMR_W'(CHIP_CYC);
   localparam logic [TMR_W-1:0] SECT_LD = TMR_W'(SECT_CYC);
   localparam logic [LAT_W-1:0] LAT_LD  = LAT_W'(SUSP_LAT);

   fes_cmd_t   cmd;
   fes_state_e st_q, st_d;
   logic             tmr_load, tmr_dec, tmr_last;
   logic [TMR_W-1:0] tmr_val, tmr_cnt;
   logic             lat_load, lat_dec, lat_last;
   logic [LAT_W-1:0] lat_cnt;
   logic             sel_one, sel_all, sel_clr, rd_hit;

   fes_decode u_dec (
      .wr_en(wr_en), .prog_active(prog_active),
      .key_addr(wr_addr[10:0]), .data(wr_data), .cmd(cmd)
   );

   fes_cnt #(.W(TMR_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
      .dec(tmr_dec), .cnt(tmr_cnt), .last(tmr_last)
   );

   fes_cnt #(.W(LAT_W)) u_lat (
      .clk(clk), .rst_n(rst_n), .load(lat_load), .load_val(LAT_LD),
      .dec(lat_dec), .cnt(lat_cnt), .last(lat_last)
   );

   fes_sect_map #(.NUM_SECT(NUM_SECT)) u_map (
      .clk(clk), .rst_n(rst_n), .set_one(sel_one), .set_all(sel_all),
      .clr(sel_clr), .wr_idx(wr_addr[ADDR_W-1 -: SECT_W]),
      .rd_idx(rd_sector), .sel(sect_sel), .rd_hit(rd_hit)
   );

   always_comb begin
      st_d     = st_q;
      tmr_load = 1'b0;
      tmr_val  = SECT_LD;
      tmr_dec  = 1'b0;
      lat_load = 1'b0;
      lat_dec  = 1'b0;
      sel_one  = 1'b0;
      sel_all  = 1'b0;
      sel_clr  = 1'b0;
      unique case (st_q)
         ST_READ:  if (cmd.key_a) st_d = ST_UNL1;
         ST_UNL1:  if (cmd.wr) st_d = cmd.key_b ? ST_UNL2 : ST_READ;
         ST_UNL2:  if (cmd.wr) st_d = cmd.setup ? ST_SETUP :
                                      cmd.ident ? ST_IDENT : ST_READ;
         ST_SETUP: if (cmd.wr) st_d = cmd.key_a ? ST_UNL3 : ST_READ;
         ST_UNL3:  if (cmd.wr) st_d = cmd.key_b ? ST_UNL4 : ST_READ;
         ST_UNL4: begin
            if (cmd.chip) begin
               st_d = ST_CHIP; tmr_load = 1'b1; tmr_val = CHIP_LD; sel_all = 1'b1;
            end else if (cmd.sect) begin
               st_d = ST_SECT; tmr_load = 1'b1; tmr_val = SECT_LD; sel_one = 1'b1;
            end else if (cmd.wr) begin
               st_d = ST_READ;
            end
         end
         ST_CHIP: begin
            if (tmr_last) begin st_d = ST_READ; sel_clr = 1'b1; end
            else tmr_dec = 1'b1;
         end
         ST_SECT: begin
            if (tmr_last) begin st_d = ST_READ; sel_clr = 1'b1; end
            else if (cmd.susp) begin st_d = ST_SWAIT; lat_load = 1'b1; end
            else tmr_dec = 1'b1;
         end
         ST_SWAIT: begin
            if (lat_last) st_d = ST_SUSP;
            else lat_dec = 1'b1;
         end
         ST_SUSP:  if (cmd.resume) st_d = ST_SECT;
         ST_IDENT: if (cmd.reset) st_d = ST_READ;
         default:  st_d = ST_READ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_READ;
      else        st_q <= st_d;
   end

   assign busy      = (st_q == ST_CHIP) || (st_q == ST_SECT) || (st_q == ST_SWAIT);
   assign suspended = (st_q == ST_SUSP);
   assign id_mode   = (st_q == ST_IDENT);
   assign rd_status = rd_hit;

   // R4: whole-device erase cannot be left before its timer expires
   assert_chip_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_CHIP && !tmr_last) |=> (st_q == ST_CHIP));
   // R6: busy and suspended are exclusive
   assert_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && suspended));
   // R6: a paused erase is entered only through the pending window
   assert_susp_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(suspended) |-> ($past(st_q) == ST_SWAIT));
   // R7: a sector-level erase keeps exactly one sector marked
   assert_one_sect_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_SECT || st_q == ST_SWAIT || st_q == ST_SUSP) |-> $onehot(sect_sel));
   // R10: read mode carries no selected sectors
   assert_idle_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_READ) |-> (sect_sel == '0));
   // R11: an owned bus leaves the command decoder where it was
   assert_prog_ignore_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_active && !busy) |=> $stable(st_q));
endmodule

// File: tb/fes_seq_test.sv
module fes_seq_test;
   localparam int AW = 12, NS = 8, CC = 60, SC = 20, SL = 3;

   logic clk = 1'b0, rst_n = 1'b0;
   logic wr_en = 1'b0, prog_active = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [2:0] rd_sector = '0;
   logic busy, suspended, id_mode, rd_status;
   logic [NS-1:0] sect_sel;

   int n_chk = 0, n_err = 0;
   bit done = 1'b0;

   fes_seq #(.ADDR_W(AW), .NUM_SECT(NS), .CHIP_CYC(CC), .SECT_CYC(SC),
             .SUSP_LAT(SL), .CLK_MHZ(250)) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .prog_active(prog_active), .rd_sector(rd_sector),
      .busy(busy), .suspended(suspended), .id_mode(id_mode),
      .sect_sel(sect_sel), .rd_status(rd_status)
   );

   always #2 clk = ~clk;

   // behavioural reference model
   localparam int M_READ = 0, M_U1 = 1, M_U2 = 2, M_SET = 3, M_U3 = 4, M_U4 = 5,
                  M_CHIP = 6, M_SECT = 7, M_SW = 8, M_SUSP = 9, M_ID = 10;
   int m_st = M_READ, m_t = 0, m_lat = 0;
   logic [NS-1:0] m_sel = '0;
   bit m_ok = 1'b0;
   bit w;
   logic [10:0] a;
   logic [7:0] d;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = M_READ; m_t = 0; m_lat = 0; m_sel = '0; m_ok = 1'b1;
      end else begin
         w = wr_en && !prog_active; a = wr_addr[10:0]; d = wr_data;
         case (m_st)
            M_READ: if (w && d == 8'hAA && a == 11'h555) m_st = M_U1;
            M_U1:   if (w) m_st = (d == 8'h55 && a == 11'h2AA) ? M_U2 : M_READ;
            M_U2:   if (w) begin
                       if (d == 8'h80 && a == 11'h555) m_st = M_SET;
                       else if (d == 8'h90 && a == 11'h555) m_st = M_ID;
                       else m_st = M_READ;
                    end
            M_SET:  if (w) m_st = (d == 8'hAA && a == 11'h555) ? M_U3 : M_READ;
            M_U3:   if (w) m_st = (d == 8'h55 && a == 11'h2AA) ? M_U4 : M_READ;
            M_U4:   if (w) begin
                       if (d == 8'h10 && a == 11'h555) begin m_st = M_CHIP; m_t = CC; m_sel = '1; end
                       else if (d == 8'h30) begin
                          m_st = M_SECT; m_t = SC; m_sel = NS'(1) << wr_addr[AW-1:AW-3];
                       end else m_st = M_READ;
                    end
            M_CHIP: if (m_t == 1) begin m_st = M_READ; m_sel = '0; end else m_t--;
            M_SECT: if (m_t == 1) begin m_st = M_READ; m_sel = '0; end
                    else if (w && d == 8'hB0) begin m_st = M_SW; m_lat = SL; end
                    else m_t--;
            M_SW:   if (m_lat == 1) m_st = M_SUSP; else m_lat--;
            M_SUSP: if (w && d == 8'h30) m_st = M_SECT;
            M_ID:   if (w && d == 8'hF0) m_st = M_READ;
            default: m_st = M_READ;
         endcase
      end
   end

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && m_ok) begin
         check("R4 busy", 32'(busy), 32'(m_st == M_CHIP || m_st == M_SECT || m_st == M_SW));
         check("R6 suspended", 32'(suspended), 32'(m_st == M_SUSP));
         check("R12 id_mode", 32'(id_mode), 32'(m_st == M_ID));
         check("R2 sect_sel", 32'(sect_sel), 32'(m_sel));
         check("R7 rd_status", 32'(rd_status), 32'(m_sel[rd_sector]));
      end
   end

   task automatic wcyc(logic [AW-1:0] ad, logic [7:0] dt);
      wr_en = 1'b1; wr_addr = ad; wr_data = dt;
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic idle(int n);
      repeat (n) begin @(posedge clk); #1; end
   endtask

   task automatic prefix();
      wcyc(12'h555, 8'hAA); wcyc(12'h2AA, 8'h55); wcyc(12'h555, 8'h80);
      wcyc(12'h555, 8'hAA); wcyc(12'h2AA, 8'h55);
   endtask

   initial begin
      int n;
      int used;
      idle(3);
      rst_n = 1'b1;
      idle(1);
      check("R10 reset busy", 32'(busy), 0);
      check("R10 reset sel", 32'(sect_sel), 0);
      check("R12 reset id", 32'(id_mode), 0);

      // R1 whole-device erase, with ignored writes (R4)
      prefix(); wcyc(12'h555, 8'h10);
      check("R1 busy", 32'(busy), 1);
      check("R1 all selected", 32'(sect_sel), 32'hFF);
      n = 0;
      wcyc(12'h123, 8'hB0); n++;
      wcyc(12'h555, 8'hAA); n++;
      check("R4 no suspend", 32'(busy), 1);
      while (busy && n < 1000) begin idle(1); n++; end
      check("R1 duration", 32'(n), CC);
      check("R4 not suspended", 32'(suspended), 0);

      // R2 sector erase on sector 5
      prefix(); wcyc(12'hA10, 8'h30);
      check("R2 one sector", 32'(sect_sel), 32'h20);
      rd_sector = 3'd5; #1 check("R7 selected reads status", 32'(rd_status), 1);
      rd_sector = 3'd1; #1 check("R7 other reads array", 32'(rd_status), 0);
      wcyc(12'h555, 8'hAA); wcyc(12'h555, 8'h10);
      check("R5 ignored writes", 32'(sect_sel), 32'h20);
      prog_active = 1'b1; wcyc(12'h123, 8'hB0); prog_active = 1'b0;
      idle(SL + 1);
      check("R11 suspend ignored", 32'(suspended), 0);
      check("R11 still busy", 32'(busy), 1);
      used = 2 + 1 + SL + 1;
      wcyc(12'h7FF, 8'hB0);
      check("R6 pending busy", 32'(busy), 1);
      n = 0;
      while (!suspended && n < 100) begin idle(1); n++; end
      check("R6 latency", 32'(n), SL);
      rd_sector = 3'd5; #1 check("R7 suspended sector status", 32'(rd_status), 1);
      rd_sector = 3'd2; #1 check("R7 suspended other array", 32'(rd_status), 0);
      wcyc(12'h555, 8'hAA); wcyc(12'h2AA, 8'h55); wcyc(12'h555, 8'h90);
      check("R9 no ident", 32'(id_mode), 0);
      wcyc(12'h555, 8'hF0);
      check("R9 still suspended", 32'(suspended), 1);
      idle(5);
      wcyc(12'h0FF, 8'h30);
      check("R8 resumed", 32'(busy), 1);
      n = 0;
      while (busy && n < 1000) begin idle(1); n++; end
      check("R8 remaining time", 32'(n), SC - used);
      rd_sector = 3'd5; #1;
      check("R10 sel cleared", 32'(sect_sel), 0);
      check("R10 status off", 32'(rd_status), 0);

      // R3 aborts: wrong address, then wrong data
      wcyc(12'h555, 8'hAA); wcyc(12'h2AA, 8'h55); wcyc(12'h555, 8'h80);
      wcyc(12'h554, 8'hAA); wcyc(12'h2AA, 8'h55); wcyc(12'h555, 8'h10);
      check("R3 address abort", 32'(busy), 0);
      wcyc(12'h555, 8'hAA); wcyc(12'h2AA, 8'h56); wcyc(12'h555, 8'h90);
      check("R3 data abort", 32'(id_mode), 0);

      // R12 identification mode
      wcyc(12'h555, 8'hAA); wcyc(12'h2AA, 8'h55); wcyc(12'h555, 8'h90);
      check("R12 ident entered", 32'(id_mode), 1);
      wcyc(12'h555, 8'hAA);
      check("R12 ident held", 32'(id_mode), 1);
      wcyc(12'h000, 8'hF0);
      check("R12 ident left", 32'(id_mode), 0);

      // R11 during an unlock string
      prog_active = 1'b1; wcyc(12'h555, 8'hAA); prog_active = 1'b0;
      wcyc(12'h2AA, 8'h55); wcyc(12'h555, 8'h90);
      check("R11 unlock ignored", 32'(id_mode), 0);

      // R13 suspend in final cycle
      prefix(); wcyc(12'h010, 8'h30);
      check("R13 sector 0", 32'(sect_sel), 32'h01);
      n = 0;
      while (!(m_st == M_SECT && m_t == 1) && n < 100) begin idle(1); n++; end
      wcyc(12'h000, 8'hB0);
      check("R13 completed", 32'(busy), 0);
      idle(SL + 1);
      check("R13 no pause", 32'(suspended), 0);
      check("R13 sel clear", 32'(sect_sel), 0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end
endmodule